// File: doc/BRIEF.md
# PCI Type 0 Configuration Header Registers

This block holds the configuration header of a PCI target function. It sits behind a fixed target core that has already dealt with the bus pins. The core shares one 32-bit bus between address and write data. When its address-valid flag is high, the block latches the dword offset from that bus. After that, every access applies to the latched offset. Each advance pulse from the core moves the offset on by one dword, so bursts walk through consecutive registers.

The header holds a fixed identity: vendor and device IDs, the class and revision word, and the subsystem IDs. It also holds a writable Command register, a Status register with two error flags, and one 32-bit memory Base Address Register that decodes a window of 2^BAR_LOG2 bytes. A dword is written when the configuration-write level and the advance pulse are both high. Only the byte lanes whose active-low enables are low are updated.

The core sends parity-error and system-error events as single-cycle pulses, and these set the matching Status flags. In the other direction, two Command bits are returned to the core as separate level outputs. Read data always reflects the dword at the latched offset.

Top module: `pci_cfg_space`

## Requirements
- R1: In a cycle with `adr_valid` high, the offset `adr_wdata[7:2]` is latched. From the next cycle on, `cfg_rdata` shows the dword at that offset.
- R2: A dword is written only in a cycle with `cfg_wr` high, `adr_inc` high and `adr_valid` low. When either `cfg_wr` or `adr_inc` is low, nothing is written.
- R3: Byte enable `cbe_n[i]` is active low and guards write-data bits `8*i+7 : 8*i`. A lane whose enable is high keeps its old value.
- R4: Offset 04h holds the Command register in bits 15:0. Only Command bits 0, 1, 6 and 8 can be written, and all other Command bits read zero. Bit 6 drives `cmd_parity_resp` and bit 8 drives `cmd_serr_enable`.
- R5: A `perr_evt` pulse sets Status bit 15 (read bit 31 at 04h). A `serr_evt` pulse sets Status bit 14 (read bit 30). Both flags hold until they are cleared. All other Status bits read zero.
- R6: A write to 04h with lane 3 enabled clears each of the two flags whose data bit is 1. Writing 0 leaves a flag as it is. If an event pulse arrives in the same cycle as a clear, the flag stays set.
- R7: The identity dwords are read-only: 00h reads {DEVICE_ID, VENDOR_ID}, 08h reads CLASS_REV, and 2Ch reads {SUBSYS_ID, SUBSYS_VID}. Every other unimplemented offset reads zero, and writes to those offsets are ignored.
- R8: BAR0 is at 10h. Bits 31:BAR_LOG2 are writable and the low bits read zero. With the default of 12, writing all ones reads back FFFFF000h: a non-prefetchable 32-bit memory window.
- R9: Each `adr_inc` pulse with `adr_valid` low advances the latched offset by one dword. The offset wraps from FCh back to 00h.
- R10: Reset clears the Command register, both Status flags and BAR0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adr_valid | input | 1 | The shared bus carries an address this cycle |
| adr_wdata | input | 32 | Shared address / write-data bus |
| cbe_n | input | 4 | Active-low byte enables (command while adr_valid is high) |
| cfg_wr | input | 1 | Level: the current access is a configuration write |
| adr_inc | input | 1 | Pulse: one dword transfer completes; advance the offset |
| perr_evt | input | 1 | Pulse: parity error detected |
| serr_evt | input | 1 | Pulse: system error signalled |
| cfg_rdata | output | 32 | Dword at the latched offset |
| cmd_parity_resp | output | 1 | Command bit 6 |
| cmd_serr_enable | output | 1 | Command bit 8 |

## Verification
Every register is visible on `cfg_rdata` as soon as the offset is latched. A corrupt offset latch or a wrong register value therefore shows up on the first read after an address phase: one cycle after the fault, or two after the write that caused it. A missed or doubled advance shifts every later dword of a burst by a fixed amount, so a walk over all sixteen header dwords exposes it at the first wrong step. Faults in the Status flags, such as a lost event or the wrong priority between clear and set, are only seen on a read of 04h. For that reason, 04h is read after every event and clear pattern.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;

    // dword indices of the implemented header registers
    localparam int IDX_ID      = 0;
    localparam int IDX_CMDSTAT = 1;
    localparam int IDX_CLASS   = 2;
    localparam int IDX_BAR0    = 4;
    localparam int IDX_SUBSYS  = 11;

    typedef struct packed {
        logic [15:0] cmd;
        logic        perr;
        logic        serr;
        logic [31:0] bar;
    } cfg_state_t;

    // replace the byte lanes whose active-low enable is low
    function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [3:0]  be_n);
        logic [31:0] r;
        r = old_v;
        for (int i = 0; i < 4; i++) begin
            if (!be_n[i]) r[8*i +: 8] = new_v[8*i +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/pci_cfg_addr.sv
module pci_cfg_addr #(
    parameter int OFFS_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [OFFS_W-1:0] load_off,
    input  logic              adv,
    output logic [OFFS_W-1:0] off_q
);
    logic [OFFS_W-1:0] off_d;

    always_comb begin
        off_d = off_q;
        if (load)     off_d = load_off;
        else if (adv) off_d = off_q + OFFS_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) off_q <= '0;
        else        off_q <= off_d;
    end
endmodule

// File: rtl/pci_cfg_regs.sv
module pci_cfg_regs
    import pci_cfg_pkg::*;
#(
    parameter int          OFFS_W    = 6,
    parameter logic [15:0] CMD_WMASK = 16'h0143,
    parameter int          BAR_LOG2  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFFS_W-1:0] off,
    input  logic [31:0]       wdata,
    input  logic [3:0]        be_n,
    input  logic              perr_evt,
    input  logic              serr_evt,
    output cfg_state_t        st_q
);
    localparam logic [31:0] BAR_MASK = {{(32-BAR_LOG2){1'b1}}, {BAR_LOG2{1'b0}}};

    cfg_state_t  st_d;
    logic [31:0] cmd_mrg;
    logic [31:0] bar_mrg;
    logic        hit_cmd;
    logic        hit_bar;

    always_comb begin
        st_d    = st_q;
        cmd_mrg = lane_merge({16'h0, st_q.cmd}, wdata, be_n);
        bar_mrg = lane_merge(st_q.bar, wdata, be_n);
        hit_cmd = wr_en && (off == OFFS_W'(IDX_CMDSTAT));
        hit_bar = wr_en && (off == OFFS_W'(IDX_BAR0));
        if (hit_cmd) begin
            st_d.cmd = cmd_mrg[15:0] & CMD_WMASK;
            if (!be_n[3]) begin
                if (wdata[31]) st_d.perr = 1'b0;
                if (wdata[30]) st_d.serr = 1'b0;
            end
        end
        if (hit_bar) st_d.bar = bar_mrg & BAR_MASK;
        // an event in the clear cycle wins
        if (perr_evt) st_d.perr = 1'b1;
        if (serr_evt) st_d.serr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pci_cfg_rdmux.sv
module pci_cfg_rdmux
    import pci_cfg_pkg::*;
#(
    parameter int          OFFS_W     = 6,
    parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID  = 16'h3C4D,
    parameter logic [31:0] CLASS_REV  = 32'h0B400002,
    parameter logic [15:0] SUBSYS_VID = 16'h5E6F,
    parameter logic [15:0] SUBSYS_ID  = 16'h7081
) (
    input  logic [OFFS_W-1:0] off,
    input  cfg_state_t        st,
    output logic [31:0]       rdata
);
    always_comb begin
        unique case (int'(off))
            IDX_ID:      rdata = {DEVICE_ID, VENDOR_ID};
            IDX_CMDSTAT: rdata = {st.perr, st.serr, 14'h0, st.cmd};
            IDX_CLASS:   rdata = CLASS_REV;
            IDX_BAR0:    rdata = st.bar;
            IDX_SUBSYS:  rdata = {SUBSYS_ID, SUBSYS_VID};
            default:     rdata = 32'h0;
        endcase
    end
endmodule

// File: rtl/pci_cfg_space.sv
module pci_cfg_space
    import pci_cfg_pkg::*;
#(
    parameter int          OFFS_W     = 6,
    parameter logic [15:0] CMD_WMASK  = 16'h0143,
    parameter int          BAR_LOG2   = 12,
    parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID  = 16'h3C4D,
    parameter logic [31:0] CLASS_REV  = 32'h0B400002,
    parameter logic [15:0] SUBSYS_VID = 16'h5E6F,
    parameter logic [15:0] SUBSYS_ID  = 16'h7081
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adr_valid,
    input  logic [31:0] adr_wdata,
    input  logic [3:0]  cbe_n,
    input  logic        cfg_wr,
    input  logic        adr_inc,
    input  logic        perr_evt,
    input  logic        serr_evt,
    output logic [31:0] cfg_rdata,
    output logic        cmd_parity_resp,
    output logic        cmd_serr_enable
);
    logic [OFFS_W-1:0] off_q;
    logic              wr_en;
    logic              adv;
    cfg_state_t        st_q;
    logic [15:0]       cmd_q;
    logic [31:0]       bar_q;
    logic              perr_q;
    logic              serr_q;

    assign wr_en = cfg_wr && adr_inc && !adr_valid;
    assign adv   = adr_inc && !adr_valid;

    pci_cfg_addr #(.OFFS_W(OFFS_W)) addr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (adr_valid),
        .load_off (adr_wdata[OFFS_W+1:2]),
        .adv      (adv),
        .off_q    (off_q)
    );

    pci_cfg_regs #(
        .OFFS_W    (OFFS_W),
        .CMD_WMASK (CMD_WMASK),
        .BAR_LOG2  (BAR_LOG2)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .off      (off_q),
        .wdata    (adr_wdata),
        .be_n     (cbe_n),
        .perr_evt (perr_evt),
        .serr_evt (serr_evt),
        .st_q     (st_q)
    );

    pci_cfg_rdmux #(
        .OFFS_W     (OFFS_W),
        .VENDOR_ID  (VENDOR_ID),
        .DEVICE_ID  (DEVICE_ID),
        .CLASS_REV  (CLASS_REV),
        .SUBSYS_VID (SUBSYS_VID),
        .SUBSYS_ID  (SUBSYS_ID)
    ) rdmux_i (
        .off   (off_q),
        .st    (st_q),
        .rdata (cfg_rdata)
    );

    assign cmd_q           = st_q.cmd;
    assign bar_q           = st_q.bar;
    assign perr_q          = st_q.perr;
    assign serr_q          = st_q.serr;
    assign cmd_parity_resp = cmd_q[6];
    assign cmd_serr_enable = cmd_q[8];
endmodule

// File: rtl/pci_cfg_space_chk.sv
module pci_cfg_space_chk #(
    parameter int          OFFS_W    = 6,
    parameter logic [15:0] CMD_WMASK = 16'h0143,
    parameter int          BAR_LOG2  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adr_valid,
    input logic [31:0]       adr_wdata,
    input logic              cfg_wr,
    input logic              adr_inc,
    input logic              perr_evt,
    input logic              serr_evt,
    input logic [31:0]       cfg_rdata,
    input logic [OFFS_W-1:0] off_q,
    input logic [15:0]       cmd_q,
    input logic [31:0]       bar_q,
    input logic              perr_q,
    input logic              serr_q
);
    AST_ADDR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        adr_valid |=> off_q == $past(adr_wdata[OFFS_W+1:2])); // R1

    AST_NO_STROBE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && adr_inc) |=> ($stable(cmd_q) && $stable(bar_q))); // R2

    AST_CMD_RO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q & ~CMD_WMASK) == 16'h0); // R4

    AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        perr_evt |=> perr_q); // R5

    AST_SERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        serr_evt |=> serr_q); // R6

    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(int'(off_q) inside {0, 1, 2, 4, 11}) |-> cfg_rdata == 32'h0); // R7

    AST_BAR_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_q[BAR_LOG2-1:0] == '0)); // R8

    AST_OFFS_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (adr_inc && !adr_valid) |=> off_q == OFFS_W'($past(off_q) + OFFS_W'(1))); // R9
endmodule

bind pci_cfg_space pci_cfg_space_chk #(
    .OFFS_W    (OFFS_W),
    .CMD_WMASK (CMD_WMASK),
    .BAR_LOG2  (BAR_LOG2)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .adr_valid (adr_valid),
    .adr_wdata (adr_wdata),
    .cfg_wr    (cfg_wr),
    .adr_inc   (adr_inc),
    .perr_evt  (perr_evt),
    .serr_evt  (serr_evt),
    .cfg_rdata (cfg_rdata),
    .off_q     (off_q),
    .cmd_q     (cmd_q),
    .bar_q     (bar_q),
    .perr_q    (perr_q),
    .serr_q    (serr_q)
);

// File: tb/pci_cfg_space_tb_top.sv
`timescale 1ns/1ps
module pci_cfg_space_tb_top;
    localparam logic [15:0] VEN  = 16'h1A2B;
    localparam logic [15:0] DEV  = 16'h3C4D;
    localparam logic [31:0] CREV = 32'h0B400002;
    localparam logic [15:0] SVID = 16'h5E6F;
    localparam logic [15:0] SID  = 16'h7081;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adr_valid = 1'b0;
    logic [31:0] adr_wdata = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        cfg_wr = 1'b0;
    logic        adr_inc = 1'b0;
    logic        perr_evt = 1'b0;
    logic        serr_evt = 1'b0;
    logic [31:0] cfg_rdata;
    logic        cmd_parity_resp;
    logic        cmd_serr_enable;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // reference state
    logic [15:0] m_cmd = '0;
    logic        m_perr = 1'b0;
    logic        m_serr = 1'b0;
    logic [31:0] m_bar = '0;

    always #10 clk = ~clk;

    pci_cfg_space dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .adr_valid       (adr_valid),
        .adr_wdata       (adr_wdata),
        .cbe_n           (cbe_n),
        .cfg_wr          (cfg_wr),
        .adr_inc         (adr_inc),
        .perr_evt        (perr_evt),
        .serr_evt        (serr_evt),
        .cfg_rdata       (cfg_rdata),
        .cmd_parity_resp (cmd_parity_resp),
        .cmd_serr_enable (cmd_serr_enable)
    );

    function automatic logic [31:0] lane_mask(input logic [3:0] be_n);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = be_n[i] ? 8'h00 : 8'hFF;
        return m;
    endfunction

    function automatic logic [31:0] exp_rd(input int idx);
        case (idx)
            0:       return {DEV, VEN};
            1:       return {m_perr, m_serr, 14'h0, m_cmd};
            2:       return CREV;
            4:       return m_bar;
            11:      return {SID, SVID};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic addr_ph(input int idx);
        @(negedge clk);
        adr_valid = 1'b1;
        adr_wdata = {24'h0, 6'(idx), 2'b00};
        cbe_n     = 4'hA;
        cfg_wr    = 1'b0;
        adr_inc   = 1'b0;
        @(negedge clk);
        adr_valid = 1'b0;
    endtask

    // one data phase starting at the current negedge
    task automatic data_ph(input logic [31:0] d, input logic [3:0] be, input logic w);
        adr_wdata = d;
        cbe_n     = be;
        cfg_wr    = w;
        adr_inc   = 1'b1;
        @(negedge clk);
        adr_inc   = 1'b0;
        cfg_wr    = 1'b0;
        cbe_n     = 4'hF;
    endtask

    task automatic wr(input int idx, input logic [31:0] d, input logic [3:0] be);
        addr_ph(idx);
        data_ph(d, be, 1'b1);
    endtask

    task automatic rd(input int idx, input string tag);
        addr_ph(idx);
        chk(cfg_rdata, exp_rd(idx), tag);
    endtask

    task automatic pulse(input logic p, input logic s);
        @(negedge clk);
        perr_evt = p;
        serr_evt = s;
        @(negedge clk);
        perr_evt = 1'b0;
        serr_evt = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected<=100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 / R7: reset image of every dword
        for (int i = 0; i < 64; i++) rd(i, "R10 reset sweep");
        chk({30'h0, cmd_parity_resp, cmd_serr_enable}, 32'h0, "R10 exported bits at reset");

        // R3 / R4: command lane sweep
        for (int b = 0; b < 16; b++) begin
            wr(1, 32'h0, 4'h0);
            wr(1, 32'h0000FFFF, 4'(b));
            m_cmd = 16'hFFFF & lane_mask(4'(b)) & 16'h0143;
            rd(1, "R4 command byte lanes");
            chk({30'h0, cmd_parity_resp, cmd_serr_enable}, {30'h0, m_cmd[6], m_cmd[8]},
                "R4 exported command bits");
        end

        // R3 / R8: BAR lane sweep
        for (int b = 0; b < 16; b++) begin
            wr(4, 32'h0, 4'h0);
            wr(4, 32'hDEADBEEF, 4'(b));
            m_bar = 32'hDEADBEEF & lane_mask(4'(b)) & 32'hFFFFF000;
            rd(4, "R8 BAR byte lanes");
        end
        wr(4, 32'hFFFFFFFF, 4'h0);
        m_bar = 32'hFFFFF000;
        rd(4, "R8 BAR size mask");

        // R7: read-only and unimplemented writes ignored
        wr(0, 32'hFFFFFFFF, 4'h0);
        wr(2, 32'hFFFFFFFF, 4'h0);
        wr(11, 32'hFFFFFFFF, 4'h0);
        wr(3, 32'hFFFFFFFF, 4'h0);
        wr(5, 32'hFFFFFFFF, 4'h0);
        wr(63, 32'hFFFFFFFF, 4'h0);
        for (int i = 0; i < 64; i++) rd(i, "R7 map after writes");

        // R2: strobes alone do not write
        wr(1, 32'h0, 4'h0);
        m_cmd = '0;
        addr_ph(1);
        adr_wdata = 32'h0000FFFF; cbe_n = 4'h0; cfg_wr = 1'b1; adr_inc = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0;
        data_ph(32'h0000FFFF, 4'h0, 1'b0);
        rd(1, "R2 level or pulse alone");
        // address phase with both strobes high must not write
        @(negedge clk);
        adr_valid = 1'b1; adr_wdata = 32'h0000FF04; cbe_n = 4'h0; cfg_wr = 1'b1; adr_inc = 1'b1;
        @(negedge clk);
        adr_valid = 1'b0; cfg_wr = 1'b0; adr_inc = 1'b0;
        chk(cfg_rdata, exp_rd(1), "R2 no write in address phase");

        // R9: burst read walk and wrap
        addr_ph(0);
        for (int k = 0; k < 16; k++) begin
            chk(cfg_rdata, exp_rd(k), "R9 burst read walk");
            data_ph(32'h0, 4'hF, 1'b0);
        end
        addr_ph(63);
        data_ph(32'h0, 4'hF, 1'b0);
        chk(cfg_rdata, exp_rd(0), "R9 offset wrap");

        // R9 / R1: burst write across 04h..10h
        addr_ph(1);
        data_ph(32'h00000003, 4'h0, 1'b1);
        data_ph(32'hFFFFFFFF, 4'h0, 1'b1);
        data_ph(32'hFFFFFFFF, 4'h0, 1'b1);
        data_ph(32'hABCDE123, 4'h0, 1'b1);
        m_cmd = 16'h0003;
        m_bar = 32'hABCDE000;
        rd(1, "R9 burst write cmd");
        rd(4, "R9 burst write BAR");
        rd(2, "R1 class after burst");

        // R5 / R6: status flags
        pulse(1'b1, 1'b0);
        m_perr = 1'b1;
        rd(1, "R5 parity flag set");
        pulse(1'b0, 1'b1);
        m_serr = 1'b1;
        rd(1, "R5 system flag set");
        repeat (3) @(negedge clk);
        rd(1, "R5 flags sticky");
        wr(1, 32'hC0000000 | {16'h0, m_cmd}, 4'b1011);
        rd(1, "R6 clear ignored without lane 3");
        wr(1, 32'h00000000 | {16'h0, m_cmd}, 4'b0111);
        rd(1, "R6 writing zero keeps flags");
        wr(1, 32'h80000000 | {16'h0, m_cmd}, 4'b0111);
        m_perr = 1'b0;
        rd(1, "R6 clear parity flag only");
        addr_ph(1);
        perr_evt = 1'b1;
        data_ph(32'hC0000000 | {16'h0, m_cmd}, 4'b0111, 1'b1);
        perr_evt = 1'b0;
        m_perr = 1'b1;
        m_serr = 1'b0;
        rd(1, "R6 event beats clear");

        // R10: reset mid-run
        wr(1, 32'h00000143, 4'h0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_cmd = '0; m_perr = 1'b0; m_serr = 1'b0; m_bar = '0;
        rd(1, "R10 command/status after reset");
        rd(4, "R10 BAR after reset");
        chk({30'h0, cmd_parity_resp, cmd_serr_enable}, 32'h0, "R10 exported bits after reset");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule